// File: doc/BRIEF.md
# Masked CRT Recombination with Consistency Check

This unit finishes a fault-resistant CRT signature. It receives two pairs of half-size exponentiation results. One pair comes from the full private exponent and the other from the exponent reduced by one. Every half value has already been offset by a random additive mask. The unit recombines each pair into a full-width value modulo N = p·q. It folds the message and the mask into both values so that a fault-free run makes them equal. It compares them, and it removes the mask only after the comparison has succeeded.

All modular products go through one shared bit-serial multiplier. The multiplier handles one multiplier bit per clock. It can reduce modulo p, reduce modulo N, or form a plain product when the result is known to fit. The primes are captured twice at start, and the two copies must still agree at check time. The output register is written at only two moments: the final unmasking step, and a forced zero. So a skipped or corrupted final step never exposes an unmasked intermediate.

Operating conditions: p and q are coprime, q < p, and the inverse input equals q⁻¹ mod p. The message and mask are below N. Each half value is below its own prime.

Top module: `crt_masked_recombiner`

## Requirements
- R1: After reset, result is 0, done is 0 and error is 0.
- R2: Let the full-exponent halves be (X+a) mod p and (X+a) mod q, where X = m·T mod N. Let the reduced-exponent halves be (T+a) mod p and (T+a) mod q. Then the run ends with error 0 and result X, which is the value (S − a − a·m) mod N computed from the checked sums.
- R3: When the two masked sums differ, the run ends with error 1 and result 0.
- R4: done is high for exactly one cycle at the end of every accepted run, whatever the outcome.
- R5: A start seen while idle is accepted. One cycle later result and error read 0. After done, result and error hold their values until the next accepted start.
- R6: A start raised while a run is in progress is ignored. Operands presented with it do not affect the result of the run in progress.
- R7: Between an accepted start and its done pulse, result reads 0 on every cycle. No masked or unmasked intermediate value reaches the port.
- R8: A half difference (high half minus low half) that goes negative is brought back into [0, p) by adding p once, and recombination is still correct.
- R9: Every reduced product stays below its modulus. Operands at N−1 produce correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| p_in | input | W | Larger prime |
| q_in | input | W | Smaller prime |
| qinv_in | input | W | q⁻¹ mod p |
| msg_in | input | 2W | Message m, below N |
| mask_in | input | 2W | Additive mask a, below N |
| sp_full_in | input | W | Masked full-exponent half mod p |
| sq_full_in | input | W | Masked full-exponent half mod q |
| sp_less_in | input | W | Masked reduced-exponent half mod p |
| sq_less_in | input | W | Masked reduced-exponent half mod q |
| result | output | 2W | Unmasked signature, or 0 |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Consistency check failed |

## Verification
The hard case is a run where the two masked sums disagree. Such runs come from an injected fault, and a driver with honest operands never produces one. The bench builds consistent operand sets from a chosen T and m, then deliberately bumps one full-exponent half by one. This forces a mismatch of the recombined value modulo N while the other path stays intact. It also raises a second start partway through a run with unrelated operands, to show that the run in progress is untouched. On every cycle of every run it watches the result port for any non-zero value before done.

// File: rtl/crt_masked_recombiner.sv
module crt_masked_recombiner #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      p_in,
  input  logic [W-1:0]      q_in,
  input  logic [W-1:0]      qinv_in,
  input  logic [2*W-1:0]    msg_in,
  input  logic [2*W-1:0]    mask_in,
  input  logic [W-1:0]      sp_full_in,
  input  logic [W-1:0]      sq_full_in,
  input  logic [W-1:0]      sp_less_in,
  input  logic [W-1:0]      sq_less_in,
  output logic [2*W-1:0]    result,
  output logic              done,
  output logic              error
);
  localparam int NW = 2 * W;
  localparam int CW = $clog2(NW + 1);
  localparam logic [2:0] LAST_STEP = 3'd6;

  typedef enum logic [2:0] {IDLE, PREP, RUN, POST, CHECK, FIN1, FIN2} state_t;
  state_t st;

  logic [W-1:0]  p_r, q_r, p_sh, q_sh, iq_r;
  logic [W-1:0]  spf_r, sqf_r, spl_r, sql_r, h1, h2;
  logic [NW-1:0] m_r, a_r, n_r, s_full, s_less, am_r;
  logic [2:0]    step;

  logic [NW-1:0] acc, mx, my, mmod;
  logic          plain;
  logic [CW-1:0] cnt;

  function automatic logic [NW-1:0] mod_add(input logic [NW-1:0] x, input logic [NW-1:0] y,
                                            input logic [NW-1:0] n);
    logic [NW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[NW-1:0];
  endfunction

  function automatic logic [NW-1:0] mod_sub(input logic [NW-1:0] x, input logic [NW-1:0] y,
                                            input logic [NW-1:0] n);
    return (x >= y) ? x - y : x + n - y;
  endfunction

  logic [W-1:0] d_full, d_less;
  assign d_full = (spf_r >= sqf_r) ? spf_r - sqf_r : spf_r + p_r - sqf_r;
  assign d_less = (spl_r >= sql_r) ? spl_r - sql_r : spl_r + p_r - sql_r;

  logic [NW-1:0] op_x, op_y, op_m;
  logic          op_plain;
  always_comb begin
    op_x = '0; op_y = '0; op_m = {{W{1'b0}}, p_r}; op_plain = 1'b0;
    case (step)
      3'd0: begin op_x = {{W{1'b0}}, d_full}; op_y = {{W{1'b0}}, iq_r}; end
      3'd1: begin op_x = {{W{1'b0}}, d_less}; op_y = {{W{1'b0}}, iq_r}; end
      3'd2: begin op_x = {{W{1'b0}}, q_r}; op_y = {{W{1'b0}}, h1}; op_plain = 1'b1; end
      3'd3: begin op_x = {{W{1'b0}}, q_r}; op_y = {{W{1'b0}}, h2}; op_plain = 1'b1; end
      3'd4: begin op_x = {{W{1'b0}}, p_r}; op_y = {{W{1'b0}}, q_r}; op_plain = 1'b1; end
      3'd5: begin op_x = m_r; op_y = s_less; op_m = n_r; end
      default: begin op_x = a_r; op_y = m_r; op_m = n_r; end
    endcase
  end

  logic [NW:0] dbl, r1, sum, r2;
  assign dbl = {acc, 1'b0};
  assign r1  = (!plain && dbl >= {1'b0, mmod}) ? dbl - {1'b0, mmod} : dbl;
  assign sum = r1 + (my[NW-1] ? {1'b0, mx} : '0);
  assign r2  = (!plain && sum >= {1'b0, mmod}) ? sum - {1'b0, mmod} : sum;

  logic check_ok;
  assign check_ok = (s_full == s_less) && (p_r == p_sh) && (q_r == q_sh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; step <= '0; done <= 1'b0; error <= 1'b0; result <= '0;
      p_r <= '0; q_r <= '0; p_sh <= '0; q_sh <= '0; iq_r <= '0;
      spf_r <= '0; sqf_r <= '0; spl_r <= '0; sql_r <= '0; h1 <= '0; h2 <= '0;
      m_r <= '0; a_r <= '0; n_r <= '0; s_full <= '0; s_less <= '0; am_r <= '0;
      acc <= '0; mx <= '0; my <= '0; mmod <= '0; plain <= 1'b0; cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          p_r <= p_in; q_r <= q_in; p_sh <= p_in; q_sh <= q_in; iq_r <= qinv_in;
          m_r <= msg_in; a_r <= mask_in;
          spf_r <= sp_full_in; sqf_r <= sq_full_in; spl_r <= sp_less_in; sql_r <= sq_less_in;
          result <= '0; error <= 1'b0; step <= '0; st <= PREP;
        end
        PREP: begin
          acc <= '0; mx <= op_x; my <= op_y; mmod <= op_m; plain <= op_plain;
          cnt <= CW'(NW); st <= RUN;
        end
        RUN: begin
          acc <= r2[NW-1:0];
          my  <= my << 1;
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= POST;
        end
        POST: begin
          case (step)
            3'd0: h1 <= acc[W-1:0];
            3'd1: h2 <= acc[W-1:0];
            3'd2: s_full <= {{W{1'b0}}, sqf_r} + acc;
            3'd3: s_less <= {{W{1'b0}}, sql_r} + acc;
            3'd4: n_r <= acc;
            3'd5: s_less <= mod_add(acc, a_r, n_r);
            default: begin
              am_r <= acc;
              s_full <= mod_add(s_full, acc, n_r);
            end
          endcase
          step <= step + 1'b1;
          st <= (step == LAST_STEP) ? CHECK : PREP;
        end
        CHECK: begin
          if (check_ok) st <= FIN1;
          else begin
            error <= 1'b1; result <= '0; done <= 1'b1; st <= IDLE;
          end
        end
        FIN1: begin
          s_full <= mod_sub(s_full, am_r, n_r);
          st <= FIN2;
        end
        default: begin
          result <= mod_sub(s_full, a_r, n_r);
          done <= 1'b1;
          st <= IDLE;
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_ERROR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> result == '0); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != FIN2 && st != CHECK && !(st == IDLE && start)) |=> $stable(result)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && start) |=> ($stable(m_r) && $stable(a_r) && $stable(spf_r) && $stable(p_sh))); // R6
  AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && !plain) |-> acc < mmod); // R9
  AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN) |-> !r2[NW]); // R9
endmodule

// File: tb/tb_crt_masked_recombiner.sv
module tb_crt_masked_recombiner;
  localparam int W = 8;
  localparam int NW = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] p_in = '0, q_in = '0, qinv_in = '0;
  logic [NW-1:0] msg_in = '0, mask_in = '0;
  logic [W-1:0] sp_full_in = '0, sq_full_in = '0, sp_less_in = '0, sq_less_in = '0;
  logic [NW-1:0] result;
  logic done, error;

  always #5 clk = ~clk;

  crt_masked_recombiner #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .p_in(p_in), .q_in(q_in), .qinv_in(qinv_in),
    .msg_in(msg_in), .mask_in(mask_in), .sp_full_in(sp_full_in), .sq_full_in(sq_full_in),
    .sp_less_in(sp_less_in), .sq_less_in(sq_less_in), .result(result), .done(done), .error(error));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  longint tp, tq, tiq, tm, ta, tspf, tsqf, tspl, tsql;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_prime(input int v);
    if (v < 2) return 1'b0;
    for (int k = 2; k * k <= v; k++) if (v % k == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int rand_prime(input int lo, input int hi);
    int v;
    do v = lo + int'($urandom % (hi - lo + 1)); while (!is_prime(v));
    return v;
  endfunction

  function automatic longint inv_mod(input longint x, input longint md);
    for (longint k = 1; k < md; k++) if ((x * k) % md == 1) return k;
    return 0;
  endfunction

  function automatic longint recomb(input longint hi, input longint lo, input longint p,
                                    input longint q, input longint iq);
    longint d;
    d = (hi >= lo) ? hi - lo : hi + p - lo;
    return lo + q * ((d * iq) % p);
  endfunction

  task automatic model(output bit merr, output longint mout);
    longint n, sfull, sless;
    n = tp * tq;
    sfull = (recomb(tspf, tsqf, tp, tq, tiq) + ta * tm) % n;
    sless = (tm * recomb(tspl, tsql, tp, tq, tiq) + ta) % n;
    merr = (sfull != sless);
    mout = merr ? 0 : ((sfull + 2 * n - ta - (ta * tm) % n) % n);
  endtask

  task automatic make_set(input int p, input int q, input longint t, input longint m, input longint a);
    longint n, x;
    tp = p; tq = q; tiq = inv_mod(q, p); tm = m; ta = a;
    n = tp * tq;
    x = (m * t) % n;
    tspf = (x + a) % tp; tsqf = (x + a) % tq;
    tspl = (t + a) % tp; tsql = (t + a) % tq;
  endtask

  task automatic drive_set();
    p_in = W'(tp); q_in = W'(tq); qinv_in = W'(tiq);
    msg_in = NW'(tm); mask_in = NW'(ta);
    sp_full_in = W'(tspf); sq_full_in = W'(tsqf);
    sp_less_in = W'(tspl); sq_less_in = W'(tsql);
  endtask

  task automatic run(input string req, input bit poke, output longint got, output bit gerr);
    bit leaked = 1'b0;
    bit seen = 1'b0;
    int cyc = 0;
    drive_set();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(result == '0 && error == 1'b0, "R5 clear on start", longint'(result), 0);
    while (!seen && cyc < 2000) begin
      if (poke && cyc == 7) begin
        p_in = 8'd7; q_in = 8'd5; qinv_in = 8'd3; msg_in = 16'd11; mask_in = 16'd9;
        sp_full_in = 8'd1; sq_full_in = 8'd2; sp_less_in = 8'd3; sq_less_in = 8'd4;
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (done) seen = 1'b1;
      else if (result != '0) leaked = 1'b1;
    end
    start = 1'b0;
    chk(seen, {req, " done seen"}, seen, 1);
    chk(!leaked, "R7 result zero while busy", leaked, 0);
    got = longint'(result);
    gerr = error;
    @(negedge clk);
    chk(done == 1'b0, "R4 done one cycle", done, 0);
    chk(longint'(result) == got && error == gerr, "R5 hold after done", longint'(result), got);
  endtask

  initial begin
    longint got, mout, x;
    bit gerr, merr;
    int borrows = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(result == '0, "R1 reset result", longint'(result), 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(error == 1'b0, "R1 reset error", error, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 30; i++) begin
      int p, q;
      longint n, t, m, a;
      p = rand_prime(131, 255);
      do q = rand_prime(3, p - 1); while (q == p);
      n = longint'(p) * q;
      t = $urandom % n; m = $urandom % n; a = $urandom % n;
      make_set(p, q, t, m, a);
      x = (m * t) % n;
      model(merr, mout);
      run("R2", 1'b0, got, gerr);
      if (tspf < tsqf || tspl < tsql) begin
        borrows++;
        chk(got == x && !gerr, "R8 borrowed difference", got, x);
      end else
        chk(got == x && !gerr, "R2 unmasked result", got, x);
      chk(got == mout && gerr == merr, "R2 model agreement", got, mout);
    end
    chk(borrows > 0, "R8 borrow cases present", borrows, 1);

    for (int i = 0; i < 10; i++) begin
      int p, q;
      longint n;
      p = rand_prime(131, 255);
      do q = rand_prime(3, p - 1); while (q == p);
      n = longint'(p) * q;
      make_set(p, q, $urandom % n, $urandom % n, $urandom % n);
      if (i % 2 == 0) tspf = (tspf + 1) % tp; else tsqf = (tsqf + 1) % tq;
      run("R3", 1'b0, got, gerr);
      chk(gerr == 1'b1, "R3 error raised", gerr, 1);
      chk(got == 0, "R3 result forced zero", got, 0);
      repeat (5) @(negedge clk);
      chk(error == 1'b1 && result == '0, "R5 error held", error, 1);
    end

    make_set(251, 241, 60490, 60490, 60490);
    run("R9", 1'b0, got, gerr);
    x = (longint'(60490) * 60490) % 60491;
    chk(got == x && !gerr, "R9 operands at N-1", got, x);

    make_set(251, 241, 0, 0, 0);
    run("R2", 1'b0, got, gerr);
    chk(got == 0 && !gerr, "R2 zero message and mask", got, 0);

    make_set(13, 11, 77, 1, 142);
    run("R2", 1'b0, got, gerr);
    chk(got == 77 && !gerr, "R2 unit message", got, 77);

    make_set(239, 199, 12345, 4321, 999);
    x = (longint'(4321) * 12345) % (239 * 199);
    run("R6", 1'b1, got, gerr);
    chk(got == x && !gerr, "R6 start while busy ignored", got, x);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule